// File: doc/BRIEF.md
# Collision Backoff Delay Controller

This block schedules retransmission for a master on a two-wire synchronous serial bus after it loses a contended start. While the master is attempting a transfer, the block watches two things: a collision report from the byte engine, and the falling edge of the data line compared against the master's own start edge. If either one shows a collision, the block pulses an abort so the master stops driving at once, and it increments a collision count.

After each collision it picks a random whole number of base slots, using truncated binary exponential backoff. The exponent is the collision count, capped at ten. It waits that many slots and then pulses retry, and the master repeats the whole attempt, including the start check. The random value comes from a free-running internal shift register. A successful transfer clears the count. If sixteen collisions happen in a row, the block raises a give-up flag and does not retry. The flag stays up until the owner starts a fresh attempt.

The base slot length is a parameter in clock cycles. Its nominal value corresponds to one millisecond at 250 MHz.

Top module: `backoff_ctrl`

## Requirements
- R1: After reset, tx_abort, retry and give_up are 0 and coll_cnt is 0.
- R2: A collision counts only while an attempt is in progress, that is, after attempt_start and before success or collision. Two things can signal it: coll_in, or a start mismatch. It makes tx_abort 1 for exactly the next cycle. A coll_in pulse outside an attempt does nothing: no abort, and the count is unchanged.
- R3: A start mismatch during an attempt is either of two cases. In the first, bus_sda falls from 1 to 0 in a cycle where own_fall is 0. In the second, own_fall is 1 while bus_sda was already 0 in the previous cycle. When own_fall and a 1-to-0 fall of bus_sda happen in the same cycle, there is no collision.
- R4: At the n-th consecutive collision, the number of slots drawn lies in 0 to 2^K − 1, where K = min(n, 10).
- R5: retry is a one-cycle pulse. It occurs r·SLOT_CYC + 1 cycles after the tx_abort pulse, where r is the number of slots drawn.
- R6: Each collision adds one to coll_cnt, and the new value is visible in the cycle tx_abort is 1.
- R7: The sixteenth consecutive collision gives tx_abort and sets give_up instead of starting a wait, and no retry follows. give_up and coll_cnt (16) hold until attempt_start. attempt_start clears both and begins a new attempt.
- R8: tx_ok clears coll_cnt to 0 in the next cycle and ends an attempt in progress without abort. It takes priority over a collision in the same cycle.
- R9: The draw varies from one collision to the next: over repeated first collisions, both r = 0 and r = 1 occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| attempt_start | input | 1 | Pulse: master begins a transfer attempt |
| own_fall | input | 1 | Pulse: master drives its start falling edge this cycle |
| bus_sda | input | 1 | Synchronised level of the shared data line |
| coll_in | input | 1 | Collision report from the byte engine |
| tx_ok | input | 1 | Pulse: transfer completed successfully |
| tx_abort | output | 1 | One-cycle pulse: stop driving the bus now |
| retry | output | 1 | One-cycle pulse: backoff expired, repeat the attempt |
| give_up | output | 1 | Consecutive collision limit reached |
| coll_cnt | output | 5 | Consecutive collision count |

## Verification
The embedded properties check these on every cycle: abort and retry are single-cycle pulses, and each abort raises the count by one. Success zeroes the count in the next cycle. give_up rises only when the count is at the limit, and retry never appears while it is high. The shift register never locks at zero, and the slot timer is never reloaded while it is running.

Some behaviour only the bench scenarios can show. These are that the measured abort-to-retry delay is a whole number of slots plus one, and that it lies within the window for the current exponent, including at the cap. They also show the mismatch and no-mismatch start patterns, that collision reports outside an attempt are ignored, that the draws actually vary, and that the full sixteen-collision give-up and its recovery work.

// File: rtl/backoff_pkg.sv
// Shared types for the collision backoff controller.
// Assumes: included first in compile order.
package backoff_pkg;

    // Controller phases: idle, attempt in progress, backoff wait, abandoned
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_GIVEUP = 2'd3
    } bo_state_e;

endpackage

// File: rtl/bo_lfsr.sv
// Free-running Galois shift register used as the backoff random source.
// Assumes: SEED is nonzero and TAPS gives a maximal-length sequence for W.
module bo_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);

    logic [W-1:0] state_q;

    // Advance the register one step every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS;
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign value = state_q;

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R9

endmodule

// File: rtl/bo_start_check.sv
// Compares the master's own start edge against the data line and merges
// the result with the external collision report.
// Assumes: bus_sda is already synchronised to clk; armed is high only
// while an attempt is in progress.
module bo_start_check (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic own_fall,
    input  logic bus_sda,
    input  logic ext_coll,
    output logic hit
);

    logic bus_q;
    logic bus_fell;
    logic mismatch;

    // Remember last line level; idle bus rests high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= 1'b1;
        end else begin
            bus_q <= bus_sda;
        end
    end

    // Foreign fall, or own fall onto a line already low
    always_comb begin
        bus_fell = bus_q & ~bus_sda;
        mismatch = (bus_fell & ~own_fall) | (own_fall & ~bus_q);
        hit      = armed & (mismatch | ext_coll);
    end

    AST_HIT_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !hit); // R2

endmodule

// File: rtl/bo_slot_timer.sv
// Counts a loaded number of base slots, each SLOT_CYC cycles long, and
// pulses done one cycle after the count is exhausted.
// Assumes: load is never issued while a count is running.
module bo_slot_timer #(
    parameter int SLOT_CYC = 250000,
    parameter int SLOT_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] load_slots,
    output logic              done
);

    localparam int CYC_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYC - 1);

    logic              run_q;
    logic [SLOT_W-1:0] slots_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              done_q;

    // Slot and cycle countdown with a registered completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            slots_q <= '0;
            cyc_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                run_q   <= 1'b1;
                slots_q <= load_slots;
                cyc_q   <= '0;
            end else if (run_q) begin
                if (slots_q == '0) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end else if (cyc_q == CYC_LAST) begin
                    cyc_q   <= '0;
                    slots_q <= slots_q - 1'b1;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end
        end
    end

    assign done = done_q;

    AST_NO_LOAD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !run_q); // R5
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run_q); // R5

endmodule

// File: rtl/backoff_ctrl.sv
// Collision backoff controller for a serial-bus master. Detects a
// collision during an attempt, aborts, draws r in [0, 2^K-1] with
// K = min(count, K_MAX), waits r base slots and pulses retry. Gives up
// after GIVEUP_LIM consecutive collisions.
// Assumes: inputs are synchronous to clk; LFSR_W >= K_MAX.
module backoff_ctrl
    import backoff_pkg::*;
#(
    parameter int SLOT_CYC   = 250000,
    parameter int K_MAX      = 10,
    parameter int GIVEUP_LIM = 16,
    parameter int LFSR_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       attempt_start,
    input  logic       own_fall,
    input  logic       bus_sda,
    input  logic       coll_in,
    input  logic       tx_ok,
    output logic       tx_abort,
    output logic       retry,
    output logic       give_up,
    output logic [4:0] coll_cnt
);

    localparam int CNT_W = $clog2(GIVEUP_LIM + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GIVEUP_LIM);
    localparam logic [CNT_W-1:0] KCAP  = CNT_W'(K_MAX);

    bo_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_next;
    logic              abort_q;
    logic              hit;
    logic              timer_load;
    logic              timer_done;
    logic [LFSR_W-1:0] rnd;
    logic [K_MAX-1:0]  draw_mask;
    logic [K_MAX-1:0]  draw;
    logic [CNT_W-1:0]  k_eff;

    bo_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    bo_start_check u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (state_q == ST_ACTIVE),
        .own_fall (own_fall),
        .bus_sda  (bus_sda),
        .ext_coll (coll_in),
        .hit      (hit)
    );

    bo_slot_timer #(.SLOT_CYC(SLOT_CYC), .SLOT_W(K_MAX)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (timer_load),
        .load_slots (draw),
        .done       (timer_done)
    );

    // Exponent from the post-increment count, capped, and masked draw
    always_comb begin
        cnt_next  = cnt_q + 1'b1;
        k_eff     = (cnt_next > KCAP) ? KCAP : cnt_next;
        draw_mask = {K_MAX{1'b1}} >> (K_MAX - int'(k_eff));
        draw      = rnd[K_MAX-1:0] & draw_mask;
    end

    // Next phase and timer load decision
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (attempt_start) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (tx_ok) begin
                    state_d = ST_IDLE;
                end else if (hit) begin
                    if (cnt_next >= LIMIT) begin
                        state_d = ST_GIVEUP;
                    end else begin
                        state_d    = ST_WAIT;
                        timer_load = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (timer_done) state_d = ST_IDLE;
            end
            ST_GIVEUP: begin
                if (attempt_start) state_d = ST_ACTIVE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase, collision count and abort pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            abort_q <= (state_q == ST_ACTIVE) & hit & ~tx_ok;
            if (tx_ok) begin
                cnt_q <= '0;
            end else if (state_q == ST_GIVEUP && attempt_start) begin
                cnt_q <= '0;
            end else if (state_q == ST_ACTIVE && hit) begin
                cnt_q <= cnt_next;
            end
        end
    end

    assign tx_abort = abort_q;
    assign retry    = timer_done;
    assign give_up  = (state_q == ST_GIVEUP);
    assign coll_cnt = 5'(cnt_q);

    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort); // R2
    AST_RETRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> !retry); // R5
    AST_ABORT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> coll_cnt == $past(coll_cnt) + 5'd1); // R6
    AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok |=> (coll_cnt == 5'd0) && !tx_abort); // R8
    AST_GIVEUP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(give_up) |-> coll_cnt == 5'(GIVEUP_LIM)); // R7
    AST_NO_RETRY_GIVEUP: assert property (@(posedge clk) disable iff (!rst_n)
        give_up |-> !retry); // R7

endmodule

// File: tb/backoff_ctrl_bench.sv
`timescale 1ns/1ps
module backoff_ctrl_bench;

    localparam int SLOT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic attempt_start = 1'b0;
    logic own_fall = 1'b0;
    logic bus_sda = 1'b1;
    logic coll_in = 1'b0;
    logic tx_ok = 1'b0;
    logic tx_abort, retry, give_up;
    logic [4:0] coll_cnt;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    backoff_ctrl #(.SLOT_CYC(SLOT)) u_backoff_ctrl (
        .clk(clk), .rst_n(rst_n), .attempt_start(attempt_start),
        .own_fall(own_fall), .bus_sda(bus_sda), .coll_in(coll_in),
        .tx_ok(tx_ok), .tx_abort(tx_abort), .retry(retry),
        .give_up(give_up), .coll_cnt(coll_cnt)
    );

    // Table: collisions before success, and whether to use the pin mismatch
    localparam int NV = 5;
    localparam int VEC_N [NV] = '{1, 2, 3, 5, 11};
    localparam bit VEC_PIN [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic begin_attempt();
        attempt_start = 1'b1;
        @(negedge clk);
        attempt_start = 1'b0;
    endtask

    task automatic succeed();
        tx_ok = 1'b1;
        @(negedge clk);
        tx_ok = 1'b0;
        check(coll_cnt == 0 && !tx_abort, "R8", int'(coll_cnt), 0);
    endtask

    // One collision in an active attempt; measures the wait to retry
    task automatic collide(input bit via_pin, input int exp_cnt, output int r);
        int k;
        int d;
        bit extra_abort;
        if (via_pin) bus_sda = 1'b0; else coll_in = 1'b1;
        @(negedge clk);
        bus_sda = 1'b1;
        coll_in = 1'b0;
        check(tx_abort == 1'b1, "R2", int'(tx_abort), 1);
        check(int'(coll_cnt) == exp_cnt, "R6", int'(coll_cnt), exp_cnt);
        k = (exp_cnt > 10) ? 10 : exp_cnt;
        d = 0;
        extra_abort = 1'b0;
        r = -1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            d++;
            if (tx_abort) extra_abort = 1'b1;
            if (retry) break;
        end
        check(retry && !extra_abort, "R5", int'(retry), 1);
        check(((d - 1) % SLOT) == 0, "R5", d, ((d - 1) / SLOT) * SLOT + 1);
        r = (d - 1) / SLOT;
        check(r < (1 << k), "R4", r, (1 << k) - 1);
        @(negedge clk);
        check(!retry, "R5", int'(retry), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r;
        bit seen0, seen1, quiet;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!tx_abort && !retry && !give_up && coll_cnt == 0, "R1",
              int'({tx_abort, retry, give_up}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(coll_cnt == 0 && !give_up, "R1", int'(coll_cnt), 0);

        // Table walk: n collisions then success
        for (int v = 0; v < NV; v++) begin
            for (int c = 1; c <= VEC_N[v]; c++) begin
                begin_attempt();
                collide(VEC_PIN[v], c, r);
            end
            begin_attempt();
            succeed();
        end

        // R2: collision report while idle is ignored
        coll_in = 1'b1;
        @(negedge clk);
        coll_in = 1'b0;
        @(negedge clk);
        check(!tx_abort && coll_cnt == 0, "R2", int'(tx_abort), 0);

        // R3: own fall together with the line fall is not a collision
        begin_attempt();
        own_fall = 1'b1;
        bus_sda = 1'b0;
        @(negedge clk);
        own_fall = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (tx_abort) quiet = 1'b0;
        end
        check(quiet && coll_cnt == 0, "R3", int'(coll_cnt), 0);
        succeed();
        // R3: own fall onto a line already low is a collision
        begin_attempt();
        own_fall = 1'b1;
        @(negedge clk);
        own_fall = 1'b0;
        bus_sda = 1'b1;
        check(tx_abort == 1'b1 && coll_cnt == 1, "R3", int'(tx_abort), 1);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (retry) break;
        end
        @(negedge clk);
        begin_attempt();
        succeed();

        // R8: success wins over a same-cycle collision
        begin_attempt();
        coll_in = 1'b1;
        tx_ok = 1'b1;
        @(negedge clk);
        coll_in = 1'b0;
        tx_ok = 1'b0;
        check(!tx_abort && coll_cnt == 0, "R8", int'(tx_abort), 0);

        // R9: repeated first collisions draw both 0 and 1
        seen0 = 1'b0;
        seen1 = 1'b0;
        for (int t = 0; t < 24; t++) begin
            repeat (t % 3) @(negedge clk);
            begin_attempt();
            collide(1'b0, 1, r);
            if (r == 0) seen0 = 1'b1;
            if (r == 1) seen1 = 1'b1;
            begin_attempt();
            succeed();
        end
        check(seen0 && seen1, "R9", int'({seen1, seen0}), 3);

        // R7: sixteen consecutive collisions give up
        for (int c = 1; c <= 15; c++) begin
            begin_attempt();
            collide(1'b0, c, r);
        end
        begin_attempt();
        coll_in = 1'b1;
        @(negedge clk);
        coll_in = 1'b0;
        check(tx_abort && give_up && coll_cnt == 16, "R7", int'(coll_cnt), 16);
        quiet = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (retry || !give_up) quiet = 1'b0;
        end
        check(quiet && coll_cnt == 16, "R7", int'(coll_cnt), 16);
        begin_attempt();
        check(!give_up && coll_cnt == 0, "R7", int'(give_up), 0);
        succeed();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule